// File: doc/BRIEF.md
# Printer Motor Controller with Stall Watchdog

This block runs the feed motors of two printers, a main receipt/journal printer and a slip printer, from a small register interface written by the host processor. Each printer channel has a drive output, a brake output and an output-enable that lets the board float both motor lines. A host write sets or clears a channel's motor-on bit. While the bit is set, the channel drives the motor and releases the brake. While it is clear, the brake is held.

Each channel watches the timing pulses that its printer mechanism returns. While the motor is running, a counter measures the gap since the last pulse. If the gap reaches a programmable limit, the channel takes the motor to be stalled. It drops the motor-on bit and raises a stall flag that the host can read. The flag stays set, and the motor stays stopped, until the host writes anything to the clear address or the block is reset.

Separately, a high level on a channel's overcurrent comparator input floats both motor outputs on the next clock. The channel's register state is not changed. A single select input steers motor-on writes and stall-clear writes to one of the two channels.

Top module: `prt_motor_ctl`

## Requirements
- R1: Writing address 0 with data bit 0 at 1 turns on the motor of the channel picked by `mode_i`, giving drive=1 and brake=0 on the next cycle. Writing it with data bit 0 at 0 gives drive=0 and brake=1. Drive and brake are never both 1.
- R2: One cycle after `oc_i[n]` is high, `oe_o[n]` is 0. One cycle after `oc_i[n]` is low, `oe_o[n]` is 1 again, and the drive and brake values are unchanged.
- R3: The stall counter of a channel counts only while that channel's motor is on. Every rising edge of the channel's `tmg_i` restarts it. Pulses that arrive more often than the limit never raise the stall flag, and a motor that is off never stalls.
- R4: When a channel's motor is on and no timing edge is seen for the programmed limit of cycles, that channel's `lock_o` goes to 1 and its motor-on bit clears (drive=0, brake=1). The flag then stays 1 until it is cleared.
- R5: While a channel's `lock_o` is 1, writes to its motor-on bit are ignored and its drive stays 0.
- R6: `mode_i`=0 selects the receipt/journal channel (index 0) and `mode_i`=1 selects the slip channel (index 1), for both address 0 and address 1 writes. Each channel keeps its own stall flag, which is not touched by writes aimed at the other channel.
- R7: A write of any data to address 1 clears the stall flag of the channel picked by `mode_i` on the next cycle.
- R8: After reset, all drive outputs are 0, all brake outputs are 1, all output enables are 1 and both stall flags are 0.
- R9: Writing address 2 loads the stall limit T from the write data. The limit is shared by both channels and starts at the `DEF_LIMIT` parameter. With no pulses, the flag rises exactly T cycles after the motor-on write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 motor-on, 1 stall clear, 2 stall limit |
| wr_data_i | input | DATA_W | Write data |
| mode_i | input | 1 | Channel select: 0 receipt/journal, 1 slip |
| tmg_i | input | 2 | Asynchronous timing pulses from each printer |
| oc_i | input | 2 | Overcurrent comparator outputs, one per channel |
| drv_o | output | 2 | Motor drive, 1 = current applied |
| brk_o | output | 2 | Motor brake, 1 = brake applied |
| oe_o | output | 2 | Motor line enable, 0 = both lines floated |
| lock_o | output | 2 | Stall flags, readable by the host |

## Verification
The bench builds the block with an 8-bit data and limit path and a default limit of 20 cycles. This keeps every stall within a few dozen cycles, so the exact-expiry cycle can be checked. It also lets random pulse periods fall on either side of the limit, including limits reprogrammed to 10 and 24. At that width the limit can be set close to the three-cycle pulse synchronizer latency. That makes the gap between "pulses keep it alive" and "stall declared" small enough to probe directly.

// File: rtl/prt_motor_pkg.sv
package prt_motor_pkg;
  localparam int unsigned NUM_PRN = 2;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MOTOR = 2'd0,
    REG_CLEAR = 2'd1,
    REG_LIMIT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/prt_pulse_sync.sv
module prt_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/prt_lock_timer.sv
module prt_lock_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    expire_o = run_i & ~restart_i & (cnt_inc >= {1'b0, limit_i});
    if (!run_i || restart_i || expire_o) cnt_d = '0;
    else                                 cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prt_motor_chan.sv
module prt_motor_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmg_i,
  input  logic             oc_i,
  input  logic             on_wr_i,
  input  logic             on_val_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             drv_o,
  output logic             brk_o,
  output logic             oe_o,
  output logic             lock_o
);
  logic mon_q, mon_d;
  logic lock_q, lock_d;
  logic oe_q, oe_d;
  logic tmg_rise, expire, run;

  prt_pulse_sync #(.STAGES(2)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(tmg_i),
    .rise_o (tmg_rise)
  );

  assign run = mon_q & ~lock_q;

  prt_lock_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(tmg_rise),
    .limit_i  (limit_i),
    .expire_o (expire)
  );

  always_comb begin
    mon_d  = mon_q;
    lock_d = lock_q;
    oe_d   = ~oc_i;
    if (expire) begin
      mon_d  = 1'b0;
      lock_d = 1'b1;
    end else begin
      if (on_wr_i && !lock_q) mon_d  = on_val_i;
      if (clr_i)              lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q  <= 1'b0;
      lock_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      mon_q  <= mon_d;
      lock_q <= lock_d;
      oe_q   <= oe_d;
    end
  end

  assign drv_o  = mon_q;
  assign brk_o  = ~mon_q;
  assign oe_o   = oe_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/prt_motor_ctl.sv
module prt_motor_ctl
  import prt_motor_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DEF_LIMIT = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 mode_i,
  input  logic [NUM_PRN-1:0]   tmg_i,
  input  logic [NUM_PRN-1:0]   oc_i,
  output logic [NUM_PRN-1:0]   drv_o,
  output logic [NUM_PRN-1:0]   brk_o,
  output logic [NUM_PRN-1:0]   oe_o,
  output logic [NUM_PRN-1:0]   lock_o
);
  localparam logic [DATA_W-1:0] LIMIT_RST = DATA_W'(DEF_LIMIT);

  logic rst_meta, rst_n_q;
  logic [DATA_W-1:0] limit_q, limit_d;
  logic wr_motor, wr_clear, wr_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {rst_n_q, rst_meta} <= 2'b00;
    else         {rst_n_q, rst_meta} <= {rst_meta, 1'b1};
  end

  always_comb begin
    wr_motor = wr_en_i && (wr_addr_i == REG_MOTOR);
    wr_clear = wr_en_i && (wr_addr_i == REG_CLEAR);
    wr_limit = wr_en_i && (wr_addr_i == REG_LIMIT);
    limit_d  = wr_limit ? wr_data_i : limit_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) limit_q <= LIMIT_RST;
    else          limit_q <= limit_d;
  end

  for (genvar g = 0; g < NUM_PRN; g++) begin : g_chan
    logic sel;
    assign sel = (mode_i == 1'(g));

    prt_motor_chan #(.CNT_W(DATA_W)) chan_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_q),
      .tmg_i   (tmg_i[g]),
      .oc_i    (oc_i[g]),
      .on_wr_i (wr_motor & sel),
      .on_val_i(wr_data_i[0]),
      .clr_i   (wr_clear & sel),
      .limit_i (limit_q),
      .drv_o   (drv_o[g]),
      .brk_o   (brk_o[g]),
      .oe_o    (oe_o[g]),
      .lock_o  (lock_o[g])
    );
  end
endmodule

// File: rtl/prt_motor_ctl_chk.sv
module prt_motor_ctl_chk
  import prt_motor_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic               mode_i,
  input logic [NUM_PRN-1:0] oc_i,
  input logic [NUM_PRN-1:0] drv_o,
  input logic [NUM_PRN-1:0] brk_o,
  input logic [NUM_PRN-1:0] oe_o,
  input logic [NUM_PRN-1:0] lock_o
);
  for (genvar g = 0; g < NUM_PRN; g++) begin : g_chk
    logic clr_me;
    assign clr_me = wr_en_i && (wr_addr_i == REG_CLEAR) && (mode_i == 1'(g));

    AST_DRV_BRK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drv_o[g] && brk_o[g])); // R1
    AST_OC_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_i[g] |=> !oe_o[g]); // R2
    AST_OC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oc_i[g] |=> oe_o[g]); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_o[g] && !clr_me) |=> lock_o[g]); // R4
    AST_LOCK_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_o[g] |-> !drv_o[g]); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_me && !drv_o[g]) |=> !lock_o[g]); // R7
  end
endmodule

bind prt_motor_ctl prt_motor_ctl_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_n_q),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .mode_i   (mode_i),
  .oc_i     (oc_i),
  .drv_o    (drv_o),
  .brk_o    (brk_o),
  .oe_o     (oe_o),
  .lock_o   (lock_o)
);

// File: tb/prt_motor_ctl_tb_top.sv
`timescale 1ns/1ps
module prt_motor_ctl_tb_top;
  localparam int DW = 8;
  localparam int DEFT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic mode = 1'b0;
  logic [1:0] tmg = '0;
  logic [1:0] oc = '0;
  logic [1:0] drv, brk, oe, lock;

  int per [2];
  bit pen [2];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int lim;

  always #2 clk = ~clk;

  prt_motor_ctl #(.DATA_W(DW), .DEF_LIMIT(DEFT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mode_i(mode), .tmg_i(tmg), .oc_i(oc),
    .drv_o(drv), .brk_o(brk), .oe_o(oe), .lock_o(lock)
  );

  initial begin : pulse_gen
    int ph [2];
    ph[0] = 0; ph[1] = 0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if (pen[c]) begin
          ph[c] = ph[c] + 1;
          tmg[c] = ((ph[c] % per[c]) < 2);
        end else begin
          ph[c] = 0;
          tmg[c] = 1'b0;
        end
      end
    end
  end

  function automatic bit exp_stall(int p, int t);
    return p > t;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d, logic m);
    wr_en = 1'b1; wr_addr = a; wr_data = d; mode = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : main
    pen[0] = 0; pen[1] = 0; per[0] = 8; per[1] = 8;
    void'($urandom(32'h1234_5eed));
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R8 reset state
    chk("R8 drv", drv, 2'b00);
    chk("R8 brk", brk, 2'b11);
    chk("R8 oe", oe, 2'b11);
    chk("R8 lock", lock, 2'b00);

    lim = DEFT;
    per[0] = 8; pen[0] = 1;
    tick(20);
    wr(2'd0, 8'h01, 1'b0);
    chk("R1 drv on", drv, 2'b01);
    chk("R1 brk released", brk, 2'b10);
    tick(200);
    chk("R3 no stall with pulses", lock, 2'b00);
    chk("R3 still driving", drv, 2'b01);

    pen[0] = 0;
    tick(lim + 8);
    chk("R4 stall flag", lock, 2'b01);
    chk("R4 motor stopped", {brk[0], drv[0]}, 2'b10);

    wr(2'd0, 8'h01, 1'b0);
    tick(2);
    chk("R5 write ignored while locked", drv[0], 1'b0);
    chk("R5 flag held", lock[0], 1'b1);

    wr(2'd1, 8'($urandom), 1'b1);
    tick(1);
    chk("R6 other channel clear ignored", lock, 2'b01);
    wr(2'd1, 8'($urandom), 1'b0);
    chk("R7 dummy write clears", lock, 2'b00);
    chk("R7 motor stays off", drv, 2'b00);

    // R9 exact expiry after new limit
    wr(2'd2, 8'd10, 1'b0);
    lim = 10;
    wr(2'd0, 8'h01, 1'b0);
    tick(lim - 1);
    chk("R9 no stall before limit", lock[0], 1'b0);
    tick(1);
    chk("R9 stall at limit", lock[0], 1'b1);
    wr(2'd1, 8'h00, 1'b0);

    // R3 off motor never stalls
    wr(2'd0, 8'h01, 1'b0);
    tick(3);
    wr(2'd0, 8'hFE, 1'b0);
    chk("R1 off gives brake", {brk[0], drv[0]}, 2'b10);
    tick(60);
    chk("R3 off motor no stall", lock, 2'b00);

    // R2 overcurrent float
    per[0] = 4; pen[0] = 1;
    tick(10);
    wr(2'd0, 8'h01, 1'b0);
    oc[0] = 1'b1;
    tick(1);
    chk("R2 lines floated", oe, 2'b10);
    chk("R2 drive value kept", drv, 2'b01);
    oc[0] = 1'b0;
    tick(1);
    chk("R2 lines restored", oe, 2'b11);
    wr(2'd0, 8'h00, 1'b0);
    pen[0] = 0;

    // R6 slip channel has its own flag
    wr(2'd0, 8'h01, 1'b1);
    chk("R6 slip drive", drv, 2'b10);
    tick(lim + 2);
    chk("R6 slip flag only", lock, 2'b10);
    wr(2'd1, 8'h5A, 1'b1);
    chk("R6 slip flag cleared", lock, 2'b00);

    // random periods against the limit
    wr(2'd2, 8'd24, 1'b0);
    lim = 24;
    for (int it = 0; it < 12; it++) begin
      int c;
      int p;
      c = int'($urandom % 2);
      if ($urandom % 2) p = 3 + int'($urandom % (lim - 8));
      else              p = lim + 6 + int'($urandom % 25);
      per[c] = p; pen[c] = 1;
      tick(p + 4);
      wr(2'd0, 8'h01, c[0]);
      tick(6 * (lim + 30));
      chk(exp_stall(p, lim) ? "R4 random stall" : "R3 random alive",
          lock[c], exp_stall(p, lim));
      chk("R5 drive vs flag", drv[c], !exp_stall(p, lim));
      wr(2'd0, 8'h00, c[0]);
      pen[c] = 0;
      wr(2'd1, 8'($urandom), c[0]);
      chk("R7 random clear", lock, 2'b00);
    end

    finish_run();
  end
endmodule